// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Overflow Interrupt

This block holds a 16-bit count that is kept as two byte registers. In timer mode it advances once every two clocks, driven by a free-running divide-by-two tick. In counter mode it advances once per falling edge of an external count pin. The pin is first passed through a two-flop synchroniser. A run bit starts and stops counting. An optional gate lets an external level hold the count, so software can measure how long the gate pin stays high.

When the count rolls over from all ones to zero, an overflow flag is set. The flag raises an interrupt request while the interrupt enable bit is set. The flag is cleared by an acknowledge pulse, which marks entry to the service routine. Software can also set or clear the flag directly. Registers are reached through a byte-wide write port and a combinational read port. Both ports use the same small register select.

Top module: `gate_timer`

## Requirements
- R1: With run=1 and ext_mode=0, the count advances by exactly one every second clock, so 2N running clocks add exactly N.
- R2: With run=1 and ext_mode=1, each high-to-low transition of cnt_pin adds one to the count. The pin must hold each level for at least 3 clocks. The new value is visible 3 clocks after the transition. Rising transitions add nothing.
- R3: While run=0, the count holds its value. Writing the control register, whether it turns run on or off, changes neither count byte.
- R4: When gate_en=1 and gate_pin=0, counting is blocked in both modes. When gate_en=0, gate_pin has no effect.
- R5: The count is one 16-bit value. A low byte of 0xFF carries into the high byte.
- R6: An advance from 0xFFFF gives 0x0000 and sets the overflow flag on the same clock edge.
- R7: irq_req is high exactly when the overflow flag is 1 and irq_en is 1.
- R8: A one-clock irq_ack pulse clears the flag. If an overflow happens on the same edge, the flag stays set.
- R9: A write to select 3 loads bit 0 of the data into the flag. This write wins over a simultaneous irq_ack.
- R10: A write to a count byte wins over an advance on the same edge. The written byte takes the data, and the other byte keeps its old value.
- R11: After reset, both count bytes, the control register and the flag read 0, and irq_req is 0.
- R12: The register select map is: 0 = count low byte, 1 = count high byte, 2 = control, 3 = flag. In the control register, bit 0 is run, bit 1 is ext_mode, bit 2 is gate_en and bit 3 is irq_en. The flag is bit 0 of select 3. rd_data follows rd_sel with no clock delay, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data for rd_sel |
| cnt_pin | input | 1 | External count input (falling edges counted) |
| gate_pin | input | 1 | External gate level, synchronous to clk |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_req | output | 1 | Interrupt request |

## Verification
Two collisions are the hardest to reach from the ports. One is an advance that lands on the same edge as a byte write. The other is an advance that lands on the same edge as an acknowledge. The divide-by-two phase cannot be observed from the ports. For that reason, the bench creates these collisions in counter mode, where the increment edge is fixed at three clocks after the bench drives cnt_pin low. It places the write or the acknowledge exactly on that edge. The timer sweeps use several start values, including ones next to the byte carry and next to the 16-bit wrap. They compare the count and the flag against values the bench computes arithmetically.

// File: rtl/gt_pkg.sv
package gt_pkg;
  // control register layout, bit 0 first from the bottom
  typedef struct packed {
    logic irq_en;   // bit 3
    logic gate_en;  // bit 2
    logic ext_mode; // bit 1
    logic run;      // bit 0
  } gt_ctrl_t;

  localparam int CTRL_W = $bits(gt_ctrl_t);
  localparam int BYTE_W = 8;
endpackage

// File: rtl/gt_tick_div.sv
module gt_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;

  always_comb begin
    tick = (ph_q == PW'(DIV - 1));
    ph_d = tick ? '0 : ph_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/gt_fall_det.sv
module gt_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // [STAGES-1:0] synchroniser, [STAGES] previous synchronised sample
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
    fall = sh_q[STAGES] & ~sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/gt_count.sv
module gt_count #(
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [NB-1:0]   lane_wr,
  input  logic [7:0]      wr_byte,
  output logic [NB*8-1:0] cnt,
  output logic            wrap
);
  localparam int W = NB * 8;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] sum;
  logic         carry;
  logic         inc;

  always_comb begin
    inc          = adv & ~(|lane_wr);
    {carry, sum} = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    wrap         = inc & carry;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      if (lane_wr[i])  cnt_d[i*8 +: 8] = wr_byte;
      else if (inc)    cnt_d[i*8 +: 8] = sum[i*8 +: 8];
      else             cnt_d[i*8 +: 8] = cnt_q[i*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[i*8 +: 8] <= '0;
      else        cnt_q[i*8 +: 8] <= cnt_d[i*8 +: 8];
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gt_flag.sv
module gt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic ack,
  output logic flag
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    if (hw_set)     flag_d = 1'b1;
    else if (sw_wr) flag_d = sw_val;
    else if (ack)   flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/gate_timer.sv
module gate_timer
  import gt_pkg::*;
#(
  parameter int CNT_BYTES   = 2,
  parameter int TICK_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(CNT_BYTES+2)-1:0]  wr_sel,
  input  logic [7:0]                      wr_data,
  input  logic [$clog2(CNT_BYTES+2)-1:0]  rd_sel,
  output logic [7:0]                      rd_data,
  input  logic                            cnt_pin,
  input  logic                            gate_pin,
  input  logic                            irq_ack,
  output logic                            irq_req
);
  localparam int ADDR_W = $clog2(CNT_BYTES + 2);
  localparam int CNT_W  = CNT_BYTES * BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] FLAG_SEL = ADDR_W'(CNT_BYTES + 1);

  gt_ctrl_t             ctrl_q;
  gt_ctrl_t             ctrl_d;
  logic                 tick_w;
  logic                 fall_w;
  logic                 adv_w;
  logic                 wrap_w;
  logic                 flag_w;
  logic                 flag_wr;
  logic [CNT_BYTES-1:0] lane_wr;
  logic                 cnt_wr_any;
  logic [CNT_W-1:0]     cnt_w;

  gt_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  gt_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(fall_w)
  );

  for (genvar i = 0; i < CNT_BYTES; i++) begin : g_wsel
    assign lane_wr[i] = wr_en && (wr_sel == ADDR_W'(i));
  end

  always_comb begin
    cnt_wr_any = |lane_wr;
    flag_wr    = wr_en && (wr_sel == FLAG_SEL);
    ctrl_d     = (wr_en && (wr_sel == CTRL_SEL)) ? gt_ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    adv_w      = ctrl_q.run
               & (~ctrl_q.gate_en | gate_pin)
               & (ctrl_q.ext_mode ? fall_w : tick_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  gt_count #(.NB(CNT_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv_w), .lane_wr(lane_wr),
    .wr_byte(wr_data), .cnt(cnt_w), .wrap(wrap_w)
  );

  gt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hw_set(wrap_w), .sw_wr(flag_wr),
    .sw_val(wr_data[0]), .ack(irq_ack), .flag(flag_w)
  );

  assign irq_req = flag_w & ctrl_q.irq_en;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (rd_sel == ADDR_W'(i)) rd_data = cnt_w[i*8 +: 8];
    end
    if (rd_sel == CTRL_SEL) rd_data = {{(8-CTRL_W){1'b0}}, ctrl_q};
    if (rd_sel == FLAG_SEL) rd_data = {7'b0, flag_w};
  end
endmodule

// File: rtl/gt_checker.sv
module gt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             gate_en,
  input logic             gate_pin,
  input logic             tick,
  input logic             adv,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wr,
  input logic             flag,
  input logic             flag_wr,
  input logic             irq_ack
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  // R1: the timebase never fires on two neighbouring clocks
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3: stopped count holds
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R4: closed gate holds the count
  a_r4_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_pin && !cnt_wr) |=> $stable(cnt));

  // R5: an advance adds exactly one below the wrap point
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_wr && cnt != ALL1) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R6: wrap to zero sets the flag on the same edge
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_wr && cnt == ALL1) |=> (cnt == '0 && flag));

  // R8: acknowledge clears the flag when nothing sets it
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !flag_wr && !(adv && !cnt_wr && cnt == ALL1)) |=> !flag);
endmodule

bind gate_timer gt_checker #(.CNT_W(CNT_W)) i_gt_checker (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .gate_en(ctrl_q.gate_en),
  .gate_pin(gate_pin), .tick(tick_w), .adv(adv_w), .cnt(cnt_w),
  .cnt_wr(cnt_wr_any), .flag(flag_w), .flag_wr(flag_wr), .irq_ack(irq_ack)
);

// File: tb/test_gate_timer.sv
`timescale 1ns/1ps
module test_gate_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       cnt_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gate_timer i_gate_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [7:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_rd(2'd0, lo); reg_rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    reg_wr(2'd0, v[7:0]); reg_wr(2'd1, v[15:8]);
  endtask

  task automatic get_flag(output logic f);
    logic [7:0] v;
    reg_rd(2'd3, v); f = v[0];
  endtask

  // run with control bits ctl for exactly 2n active edges (n >= 1)
  task automatic run_timer(input logic [7:0] ctl, input int n);
    reg_wr(2'd2, ctl | 8'h01);
    repeat (2*n - 1) @(negedge clk);
    reg_wr(2'd2, ctl & 8'hFE);
  endtask

  task automatic pin_fall();
    cnt_pin = 1'b0; repeat (3) @(negedge clk);
  endtask
  task automatic pin_rise();
    cnt_pin = 1'b1; repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, st, c0;
    logic [7:0]  v;
    logic        f;
    logic [16:0] sum;
    logic [15:0] starts [4];
    starts[0] = 16'h0000; starts[1] = 16'h00FE; starts[2] = 16'h12F0; starts[3] = 16'hFFFD;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R12: reset values of every register
    for (int s = 0; s < 4; s++) begin
      reg_rd(2'(s), v);
      check($sformatf("R11 reset sel%0d", s), v, 8'h00);
    end
    check("R11 reset irq_req", irq_req, 1'b0);

    // R12: control readback, unused bits zero
    reg_wr(2'd2, 8'hFE);
    reg_rd(2'd2, v); check("R12 ctrl readback", v, 8'h0E);
    reg_wr(2'd2, 8'h00);

    // R1 / R5 / R6: timer sweep
    foreach (starts[k]) begin
      for (int n = 1; n <= 8; n++) begin
        st = starts[k];
        set_cnt(st);
        reg_wr(2'd3, 8'h00);
        run_timer(8'h00, n);
        sum = {1'b0, st} + 17'(n);
        get_cnt(c);
        check($sformatf("R1/R5 timer start %0h n %0d", st, n), c, sum[15:0]);
        get_flag(f);
        check($sformatf("R6 flag start %0h n %0d", st, n), f, sum[16]);
      end
    end

    // R3: stopped count holds; control writes leave count alone
    set_cnt(16'h3456);
    repeat (12) @(negedge clk);
    reg_wr(2'd2, 8'h0C); reg_wr(2'd2, 8'h02); reg_wr(2'd2, 8'h00);
    get_cnt(c); check("R3 stopped hold", c, 16'h3456);

    // R4: gate in timer mode
    set_cnt(16'h0100);
    gate_pin = 1'b0; run_timer(8'h04, 5);
    get_cnt(c); check("R4 gate closed timer", c, 16'h0100);
    gate_pin = 1'b1; run_timer(8'h04, 5);
    get_cnt(c); check("R4 gate open timer", c, 16'h0105);
    gate_pin = 1'b0; run_timer(8'h00, 3);
    get_cnt(c); check("R4 gate disabled", c, 16'h0108);

    // R2: counter mode sweep
    for (int kk = 0; kk <= 6; kk++) begin
      set_cnt(16'h00FC);
      reg_wr(2'd2, 8'h03);
      for (int p = 0; p < kk; p++) begin
        pin_fall();
        get_cnt(c);
        check($sformatf("R2 after fall %0d of %0d", p+1, kk), c, 16'h00FC + 16'(p+1));
        pin_rise();
        get_cnt(c);
        check($sformatf("R2 rise ignored %0d", p+1), c, 16'h00FC + 16'(p+1));
      end
      reg_wr(2'd2, 8'h00);
      get_cnt(c); check($sformatf("R2/R5 total %0d", kk), c, 16'h00FC + 16'(kk));
    end

    // R4: gate in counter mode
    set_cnt(16'h0000);
    reg_wr(2'd2, 8'h07); gate_pin = 1'b0;
    pin_fall(); pin_rise();
    get_cnt(c); check("R4 gate closed counter", c, 16'h0000);
    gate_pin = 1'b1;
    pin_fall(); pin_rise();
    get_cnt(c); check("R4 gate open counter", c, 16'h0001);
    reg_wr(2'd2, 8'h00);

    // R10: byte write collides with increment edge
    reg_wr(2'd2, 8'h03);
    set_cnt(16'h0040);
    cnt_pin = 1'b0; @(negedge clk); @(negedge clk);
    reg_wr(2'd0, 8'h77);
    get_cnt(c); check("R10 low write wins", c, 16'h0077);
    pin_rise(); pin_fall();
    get_cnt(c); check("R10 later advance", c, 16'h0078);
    cnt_pin = 1'b1; repeat (3) @(negedge clk);
    cnt_pin = 1'b0; @(negedge clk); @(negedge clk);
    reg_wr(2'd1, 8'h12);
    get_cnt(c); check("R10 high write wins", c, 16'h1278);
    pin_rise();

    // R8: overflow and acknowledge on the same edge
    set_cnt(16'hFFFF);
    reg_wr(2'd3, 8'h00);
    cnt_pin = 1'b0; @(negedge clk); @(negedge clk);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    get_flag(f); check("R8 set beats ack", f, 1'b1);
    get_cnt(c); check("R6 wrap value", c, 16'h0000);
    pin_rise();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    get_flag(f); check("R8 ack clears", f, 1'b0);
    reg_wr(2'd2, 8'h00);

    // R7: interrupt request gating
    reg_wr(2'd3, 8'h01);
    #1; check("R7 irq off while disabled", irq_req, 1'b0);
    reg_wr(2'd2, 8'h08);
    #1; check("R7 irq on", irq_req, 1'b1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    #1; check("R7 irq drops after ack", irq_req, 1'b0);

    // R9: software write of the flag, and priority over ack
    reg_wr(2'd3, 8'h01);
    get_flag(f); check("R9 sw set", f, 1'b1);
    reg_wr(2'd3, 8'h00);
    get_flag(f); check("R9 sw clear", f, 1'b0);
    irq_ack = 1'b1; reg_wr(2'd3, 8'h01); irq_ack = 1'b0;
    get_flag(f); check("R9 write beats ack", f, 1'b1);
    reg_wr(2'd3, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule